// File: doc/BRIEF.md
# Master Clock Rate Detecting Prescaler

This block sits on the master clock of a voice codec. It finds out on its own how fast that clock runs, so no divider has to be set up by hand. It counts master-clock cycles between successive rising edges of frame sync. That count is matched against a fixed table of seven supported rates, from 256 kHz up to 4096 kHz. The matched rate picks a division ratio, which produces a clock enable that fires 32 times per frame (the internal 256 kHz tick) and a one-cycle sample strobe once per frame (the 8 kHz tick).

The block also controls low-power standby. Standby is entered in two cases: the power-up input goes low, or frame sync stays low for longer than a frame while the master clock keeps running. Standby is left only when power-up is high and frame sync edges are present again. The serial transmit path is then held back for two more frame periods before the block allows it to drive.

Frame sync is asynchronous to the master clock and passes through a two-flop synchroniser. The power-up input is taken as already synchronous to the master clock.

Top module: `mclk_rate_prescaler`

## Requirements
- R1: While and after reset, with no frame sync edges, `standby` is 1, `tx_allow` is 0, `en_256k` and `strobe_8k` are 0, and `rate_code` is 7, the code for "no rate known".
- R2: Each measured count of cycles per frame maps to a `rate_code`, and each count may be up to 2 cycles above or below the nominal value. The codes are: 0 for 32 (256 kHz), 1 for 64 (512 kHz), 2 for 192 (1536 kHz), 3 for 193 (1544 kHz), 4 for 256 (2048 kHz), 5 for 320 (2560 kHz), and 6 for 512 (4096 kHz).
- R3: The two overlapping bands are split. Counts 190 to 192 give code 2, and counts 193 to 195 give code 3.
- R4: `rate_code` changes only after two consecutive frames measure counts in the same band. A single odd frame leaves it unchanged, and it never returns to 7.
- R5: A count that falls in no band leaves `rate_code` unchanged.
- R6: Once locked and awake, `en_256k` pulses exactly 32 times per frame, spaced count/32 cycles apart. The first pulse coincides with `strobe_8k`.
- R7: At code 3, the pulses are 6 cycles apart. The single spare cycle of each 193-cycle frame is absorbed at the frame boundary.
- R8: `strobe_8k` pulses once per frame, for one cycle. That cycle starts at the second rising mclk edge after the first edge that samples frame sync high.
- R9: If no frame sync edge arrives within (top of the locked rate's band + 1) cycles, the block enters standby. Enables stop and `tx_allow` drops.
- R10: `pwr_up` low forces `standby` high from the next cycle on.
- R11: With `pwr_up` high, a frame sync edge wakes the block from standby. `tx_allow` rises only after two further frame sync edges, and `tx_allow` is never high in standby.
- R12: `en_256k` and `strobe_8k` stay low while in standby, and also before any rate is known.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fsync | input | 1 | Frame sync, asynchronous to mclk |
| pwr_up | input | 1 | Power-up request, synchronous to mclk |
| en_256k | output | 1 | Clock enable, 32 pulses per frame |
| strobe_8k | output | 1 | One-cycle sample strobe per frame |
| rate_code | output | 3 | Detected master-clock rate (7 means none) |
| standby | output | 1 | Low-power standby is active |
| tx_allow | output | 1 | Serial transmit output may leave high impedance |

## Verification
The assertions assume the following about the inputs:
- Frame sync high pulses are short compared with a frame, so the synchronised edge lasts exactly one cycle.
- Frame sync and `pwr_up` change only between clock edges.
- Reset is held for several cycles, so every `$past` term sees reset values.

The bench drives frame sync at the falling clock edge, as single-cycle pulses with exact frame lengths. `pwr_up` is changed only at the falling edge. Frame sync is stopped only for whole stretches longer than the timeout, and never in the middle of a pulse.

// File: rtl/mrp_pkg.sv
// Package: shared constants, the rate table and the power-state type
// for the master clock rate detecting prescaler.
// Assumes the rate codes are 3 bits wide, with code 7 kept for "no rate known".
package mrp_pkg;
    localparam int          NUM_RATES = 7;
    localparam int          SLOTS     = 32;  // enables per frame
    localparam int          TOL       = 2;   // allowed count error
    localparam logic [2:0]  RATE_NONE = 3'd7;

    typedef enum logic [1:0] {PWR_SLEEP, PWR_WARM, PWR_RUN} pwr_state_t;

    // Nominal mclk cycles per frame for a rate code.
    function automatic int nominal_count(input logic [2:0] code);
        case (code)
            3'd0:    return 32;
            3'd1:    return 64;
            3'd2:    return 192;
            3'd3:    return 193;
            3'd4:    return 256;
            3'd5:    return 320;
            default: return 512;
        endcase
    endfunction

    // Lowest count accepted for a code; the 192/193 overlap is split.
    function automatic int band_lo(input logic [2:0] code);
        if (code == 3'd3) return 193;
        return nominal_count(code) - TOL;
    endfunction

    // Highest count accepted for a code.
    function automatic int band_hi(input logic [2:0] code);
        if (code == 3'd2) return 192;
        return nominal_count(code) + TOL;
    endfunction

    // Cycles between enables; 193/32 truncates to 6.
    function automatic int divisor(input logic [2:0] code);
        return nominal_count(code) / SLOTS;
    endfunction
endpackage

// File: rtl/mrp_fsync_edge.sv
// Module: brings asynchronous frame sync into the mclk domain through a
// SYNC_STAGES-deep flop chain and flags its rising edge for one cycle.
// Assumes each frame sync high pulse is shorter than a frame.
module mrp_fsync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fsync_async,
    output logic rise
);
    logic [SYNC_STAGES:0] sh;

    // Shift frame sync through the synchroniser plus one edge-detect flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[SYNC_STAGES-1:0], fsync_async};
    end

    // Rising edge: the last synchronised stage is high, the flop behind it low.
    always_comb rise = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
endmodule

// File: rtl/mrp_frame_meter.sv
// Module: counts mclk cycles between frame edges and classifies each count
// against the rate table. It commits a new rate after two consecutive
// matching frames. It also flags a missing frame edge once the count
// passes the band of the locked rate.
// Assumes rise is a single-cycle pulse.
module mrp_frame_meter
    import mrp_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rise,
    output logic [2:0] rate_code,
    output logic       locked,
    output logic       absent
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] meas;
    logic             seen;
    logic [2:0]       cand_code;
    logic             cand_ok;
    logic [2:0]       rate_q;
    logic             absent_q;
    logic [2:0]       meas_code;
    logic             meas_ok;
    int               limit;

    // Classify the count that a frame edge in this cycle would close.
    always_comb begin
        meas      = cnt + 1'b1;
        meas_ok   = 1'b0;
        meas_code = RATE_NONE;
        for (int i = 0; i < NUM_RATES; i++) begin
            if (!meas_ok && int'(meas) >= band_lo(3'(i)) && int'(meas) <= band_hi(3'(i))) begin
                meas_ok   = 1'b1;
                meas_code = 3'(i);
            end
        end
    end

    // Timeout: the top of the locked band, or of the slowest band before lock.
    always_comb limit = (rate_q != RATE_NONE) ? band_hi(rate_q) : band_hi(3'd6);

    // Cycle counter, restarted by each frame edge and saturating at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (rise)       cnt <= '0;
        else if (cnt != '1)  cnt <= cnt + 1'b1;
    end

    // Missing-frame flag: set past the timeout, cleared by the next edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                  absent_q <= 1'b0;
        else if (rise)               absent_q <= 1'b0;
        else if (int'(cnt) >= limit) absent_q <= 1'b1;
    end

    // Two-frame qualification of the measured rate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen      <= 1'b0;
            cand_code <= RATE_NONE;
            cand_ok   <= 1'b0;
            rate_q    <= RATE_NONE;
        end else if (rise) begin
            seen <= 1'b1;
            if (seen) begin
                if (meas_ok) begin
                    if (cand_ok && cand_code == meas_code) rate_q <= meas_code;
                    cand_code <= meas_code;
                    cand_ok   <= 1'b1;
                end else begin
                    cand_ok <= 1'b0;
                end
            end
        end
    end

    // Drive the outputs from the registered state.
    always_comb begin
        rate_code = rate_q;
        locked    = (rate_q != RATE_NONE);
        absent    = absent_q;
    end
endmodule

// File: rtl/mrp_enable_gen.sv
// Module: divides mclk by the ratio of the current rate code. It gives
// SLOTS enables per frame, the first on the frame edge. Any spare cycles
// at the end of a frame are swallowed, and the frame strobe is emitted.
// Assumes rise is a single-cycle pulse and run is already qualified.
module mrp_enable_gen
    import mrp_pkg::*;
#(
    parameter int DIV_W  = 5,
    parameter int SLOT_W = $clog2(SLOTS + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rise,
    input  logic       run,
    input  logic [2:0] rate_code,
    output logic       en,
    output logic       strobe
);
    logic [DIV_W-1:0]  phase;
    logic [SLOT_W-1:0] slot_cnt;
    int                div;
    logic              en_now;

    // Decide whether this cycle carries an enable.
    always_comb begin
        div    = divisor(rate_code);
        en_now = run && (rise || (phase == '0 && int'(slot_cnt) < SLOTS));
    end

    // Phase counter, realigned to each frame edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                   phase <= '0;
        else if (rise)                phase <= (div == 1) ? '0 : DIV_W'(1);
        else if (int'(phase) >= div - 1) phase <= '0;
        else                          phase <= phase + 1'b1;
    end

    // Enables issued in the current frame, capped at SLOTS.
    always_ff @(posedge clk) begin
        if (!rst_n)      slot_cnt <= '0;
        else if (rise)   slot_cnt <= SLOT_W'(1);
        else if (en_now) slot_cnt <= slot_cnt + 1'b1;
    end

    // Outputs.
    always_comb begin
        en     = en_now;
        strobe = run && rise;
    end
endmodule

// File: rtl/mrp_pwr_ctrl.sv
// Module: standby and wake sequencer. Sleep is forced by a low power-up
// input or by a missing frame. Wake starts on a frame edge once a rate is
// known, and transmit is allowed after WAKE_FRAMES further edges.
// Assumes pwr_up is synchronous to clk.
module mrp_pwr_ctrl
    import mrp_pkg::*;
#(
    parameter int WAKE_FRAMES = 2,
    parameter int FC_W        = $clog2(WAKE_FRAMES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_up,
    input  logic absent,
    input  logic locked,
    input  logic rise,
    output logic standby,
    output logic tx_allow
);
    pwr_state_t      state;
    logic [FC_W-1:0] fcnt;

    // Power state machine with frame counting in the wake state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PWR_SLEEP;
            fcnt  <= '0;
        end else if (!pwr_up || absent) begin
            state <= PWR_SLEEP;
            fcnt  <= '0;
        end else begin
            case (state)
                PWR_SLEEP: if (rise && locked) begin
                    state <= PWR_WARM;
                    fcnt  <= '0;
                end
                PWR_WARM: if (rise) begin
                    if (int'(fcnt) == WAKE_FRAMES - 1) state <= PWR_RUN;
                    else                              fcnt  <= fcnt + 1'b1;
                end
                default: state <= PWR_RUN;
            endcase
        end
    end

    // Decode the state to outputs.
    always_comb begin
        standby  = (state == PWR_SLEEP);
        tx_allow = (state == PWR_RUN);
    end
endmodule

// File: rtl/mclk_rate_prescaler.sv
// Module: top of the master clock rate detecting prescaler. Frame sync is
// synchronised and measured against mclk to pick a rate. The derived
// enables run only while awake, and the standby/wake sequence is handled.
// Assumes a free-running mclk and a synchronous power-up input.
module mclk_rate_prescaler
    import mrp_pkg::*;
#(
    parameter int CNT_W       = 11,
    parameter int SYNC_STAGES = 2,
    parameter int WAKE_FRAMES = 2
) (
    input  logic       mclk,
    input  logic       rst_n,
    input  logic       fsync,
    input  logic       pwr_up,
    output logic       en_256k,
    output logic       strobe_8k,
    output logic [2:0] rate_code,
    output logic       standby,
    output logic       tx_allow
);
    logic rise;
    logic locked;
    logic absent;
    logic run;

    mrp_fsync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(mclk), .rst_n(rst_n), .fsync_async(fsync), .rise(rise)
    );

    mrp_frame_meter #(.CNT_W(CNT_W)) u_meter (
        .clk(mclk), .rst_n(rst_n), .rise(rise),
        .rate_code(rate_code), .locked(locked), .absent(absent)
    );

    mrp_pwr_ctrl #(.WAKE_FRAMES(WAKE_FRAMES)) u_pwr (
        .clk(mclk), .rst_n(rst_n), .pwr_up(pwr_up), .absent(absent),
        .locked(locked), .rise(rise), .standby(standby), .tx_allow(tx_allow)
    );

    // Enables run only when a rate is known and the block is awake.
    always_comb run = locked && !standby;

    mrp_enable_gen u_en (
        .clk(mclk), .rst_n(rst_n), .rise(rise), .run(run),
        .rate_code(rate_code), .en(en_256k), .strobe(strobe_8k)
    );
endmodule

// File: rtl/mclk_rate_prescaler_chk.sv
// Module: property checker for the prescaler, bound to the top module.
// Assumes reset is held for several cycles before release.
module mclk_rate_prescaler_chk (
    input logic       mclk,
    input logic       rst_n,
    input logic       pwr_up,
    input logic       en_256k,
    input logic       strobe_8k,
    input logic [2:0] rate_code,
    input logic       standby,
    input logic       tx_allow
);
    p_pwr_low_sleep_r10: assert property (@(posedge mclk) disable iff (!rst_n)
        !pwr_up |=> standby);

    p_en_awake_r12: assert property (@(posedge mclk) disable iff (!rst_n)
        (en_256k || strobe_8k) |-> !standby);

    p_strobe_with_en_r6: assert property (@(posedge mclk) disable iff (!rst_n)
        strobe_8k |-> en_256k);

    p_strobe_single_r8: assert property (@(posedge mclk) disable iff (!rst_n)
        strobe_8k |=> !strobe_8k);

    p_tx_awake_r11: assert property (@(posedge mclk) disable iff (!rst_n)
        tx_allow |-> !standby);

    p_tx_from_warm_r11: assert property (@(posedge mclk) disable iff (!rst_n)
        $rose(tx_allow) |-> $past(!standby));

    p_rate_no_revert_r4: assert property (@(posedge mclk) disable iff (!rst_n)
        !$stable(rate_code) |-> rate_code != 3'd7);
endmodule

bind mclk_rate_prescaler mclk_rate_prescaler_chk u_chk (
    .mclk(mclk), .rst_n(rst_n), .pwr_up(pwr_up), .en_256k(en_256k),
    .strobe_8k(strobe_8k), .rate_code(rate_code), .standby(standby),
    .tx_allow(tx_allow)
);

// File: tb/mclk_rate_prescaler_tb.sv
`timescale 1ns/1ps
module mclk_rate_prescaler_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fsync = 1'b0;
    logic       pwr_up = 1'b0;
    logic       en_256k, strobe_8k, standby, tx_allow;
    logic [2:0] rate_code;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Results of the last frame window.
    int w_en, w_st, w_st_idx, w_gmin, w_gmax;

    always #4 clk = ~clk;

    mclk_rate_prescaler u_dut (
        .mclk(clk), .rst_n(rst_n), .fsync(fsync), .pwr_up(pwr_up),
        .en_256k(en_256k), .strobe_8k(strobe_8k), .rate_code(rate_code),
        .standby(standby), .tx_allow(tx_allow)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Send n frames of p cycles each, with a one-cycle sync pulse, sampling at negedge.
    task automatic frames(input int p, input int n);
        for (int f = 0; f < n; f++) begin
            int last = -1;
            w_en = 0; w_st = 0; w_st_idx = -1; w_gmin = 100000; w_gmax = 0;
            for (int i = 0; i < p; i++) begin
                fsync = (i == 0);
                @(negedge clk);
                if (en_256k) begin
                    if (last >= 0) begin
                        if (i - last < w_gmin) w_gmin = i - last;
                        if (i - last > w_gmax) w_gmax = i - last;
                    end
                    last = i;
                    w_en++;
                end
                if (strobe_8k) begin w_st++; w_st_idx = i; end
            end
        end
    endtask

    task automatic t_reset();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 standby", int'(standby), 1);
        chk("R1 tx_allow", int'(tx_allow), 0);
        chk("R1 rate_code", int'(rate_code), 7);
        chk("R1 en_256k", int'(en_256k), 0);
        pwr_up = 1'b1;
        frames(64, 2);
        chk("R12 no enables before lock", w_en, 0);
        chk("R12 no strobe before lock", w_st, 0);
    endtask

    task automatic t_rates();
        int p_tab[7] = '{32, 64, 192, 193, 256, 320, 512};
        for (int k = 0; k < 7; k++) begin
            frames(p_tab[k], 8);
            frames(p_tab[k], 1);
            chk($sformatf("R2 rate_code p=%0d", p_tab[k]), int'(rate_code), k);
            chk($sformatf("R6 enables p=%0d", p_tab[k]), w_en, 32);
            chk($sformatf("R6 min gap p=%0d", p_tab[k]), w_gmin, p_tab[k] / 32);
            chk($sformatf("R6 max gap p=%0d", p_tab[k]), w_gmax, p_tab[k] / 32);
            chk($sformatf("R8 strobes p=%0d", p_tab[k]), w_st, 1);
            chk($sformatf("R8 strobe cycle p=%0d", p_tab[k]), w_st_idx, 1);
            chk($sformatf("R11 tx_allow p=%0d", p_tab[k]), int'(tx_allow), 1);
            if (p_tab[k] == 193) chk("R7 gap at 1544", w_gmax, 6);
        end
    endtask

    task automatic t_bands();
        frames(195, 4);
        chk("R3 count 195 gives code 3", int'(rate_code), 3);
        frames(190, 4);
        chk("R3 count 190 gives code 2", int'(rate_code), 2);
        chk("R3 no standby on band move", int'(standby), 0);
    endtask

    task automatic t_invalid();
        frames(186, 4);
        chk("R5 invalid count keeps code", int'(rate_code), 2);
        chk("R5 invalid count keeps awake", int'(standby), 0);
    endtask

    task automatic t_single();
        frames(512, 8);
        chk("R4 relock 512", int'(rate_code), 6);
        frames(256, 1);
        frames(512, 1);
        chk("R4 single odd frame ignored", int'(rate_code), 6);
        frames(512, 2);
        chk("R4 code stays after odd frame", int'(rate_code), 6);
        chk("R4 still running", int'(tx_allow), 1);
    endtask

    task automatic t_absent();
        int tail_en = 0;
        fsync = 1'b0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (i >= 550 && en_256k) tail_en++;
        end
        chk("R9 standby on missing frame", int'(standby), 1);
        chk("R9 tx_allow dropped", int'(tx_allow), 0);
        chk("R9 enables stopped", tail_en, 0);
        chk("R9 rate kept", int'(rate_code), 6);
    endtask

    task automatic t_pwr();
        frames(512, 8);
        chk("R11 awake before power-down", int'(tx_allow), 1);
        pwr_up = 1'b0;
        @(negedge clk);
        chk("R10 standby one cycle after pwr_up low", int'(standby), 1);
        frames(512, 2);
        chk("R12 no enables in standby", w_en, 0);
        chk("R12 no strobe in standby", w_st, 0);
        pwr_up = 1'b1;
        frames(512, 1);
        chk("R11 woken after first edge", int'(standby), 0);
        chk("R11 tx held frame 1", int'(tx_allow), 0);
        frames(512, 1);
        chk("R11 tx held frame 2", int'(tx_allow), 0);
        frames(512, 1);
        chk("R11 tx allowed after two frames", int'(tx_allow), 1);
    endtask

    initial begin
        t_reset();
        t_rates();
        t_bands();
        t_invalid();
        t_single();
        t_absent();
        t_pwr();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule